// File: doc/BRIEF.md
# Two-Wire Serial Memory Target Engine

This block is the target side of a byte-addressed serial memory on a two-wire bus. It runs on a fast system clock and oversamples the clock and data lines through a synchroniser. From the sampled levels it finds bus conditions and recovers bits. It decodes a control byte and then takes a two-byte word address. After that it either gathers write data into a page buffer or shifts array data back out. The only thing it drives on the data line is an open-drain pull-down enable, which the pad ring combines with the external pull-up.

A word pointer survives from one transaction to the next, so a read that gives no address carries on from where the last access stopped. Write data is held in a page buffer while the transfer runs. When a Stop ends a write that stored at least one byte, the buffer is copied into the array during a fixed busy window. For the whole of that window the engine stays silent on the bus, so a host can poll it to find out when the write has finished.

Top module: `i2cmem_slave`

## Requirements
- R1: While the clock line is high, a falling data line is a Start and a rising data line is a Stop. A Start makes the engine wait for a control byte. A Stop returns it to idle. After either, the pull-down is released.
- R2: The control byte arrives MSB first. Bits 7:4 are the type code 1010, bits 3:1 must equal selPins[2:0] (bit 3 matched against selPins[2]), and bit 0 selects the direction (1 = read, 0 = write). The engine acknowledges the byte only when both fields match and no write cycle is running. Otherwise it stays silent until the next Start.
- R3: After a write-mode control byte, the engine takes two address bytes, high byte first, and forms a 15-bit word pointer from them. Bit 7 of the high byte is ignored.
- R4: Each acknowledge pulls the data line low from the clock fall that ends bit 8 until the clock fall that ends bit 9.
- R5: The engine acknowledges each write data byte and places it in the page buffer at the pointer. Only the low 6 bits of the pointer then advance, so data wraps inside its 64-byte page and later bytes overwrite earlier ones.
- R6: A read-mode control byte with no address in front of it returns the byte at the stored pointer. The pointer then advances by one.
- R7: A write-mode control byte with two address bytes, followed by a repeated Start and a read-mode control byte, reads from the new address. No write cycle is started, so a control byte sent right afterwards is acknowledged.
- R8: In a read, a host acknowledge fetches the next byte. A host not-acknowledge releases the line. The pointer wraps from 0x7FFF to 0x0000.
- R9: A Stop that ends a write carrying at least one data byte starts a busy window of WRITE_CYCLES system clocks. During that window nothing is acknowledged, and the array is updated from the page buffer.
- R10: Read data goes out MSB first. Each bit is placed on the line only after a clock fall.
- R11: A Start aborts any partly received byte and clears the bit count. Page data from a write that ends with a repeated Start instead of a Stop is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the serial clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Serial clock line level |
| sdaIn | input | 1 | Serial data line level (wired bus value) |
| selPins | input | 3 | Strapped select value compared against control bits 3:1 |
| sdaOe | output | 1 | Open-drain enable; 1 pulls the data line low |

## Verification
The assertions run on every cycle. They check that the pull-down moves only just after a detected clock fall, and that it stays released during the busy window and right after a Start or Stop. They also check that a read fetch advances the pointer by exactly one with wrap, that a stored write byte leaves the page bits of the pointer alone, and that at most one datapath action is requested per cycle. Only the bench scenarios can show what the block does end to end. These cover control-byte matching, the pointer persisting between transactions, page wrap, the 0x7FFF rollover, the random-read path that writes nothing, and aborts on a repeated Start. They also cover the busy window, which makes polls go unanswered until the array update has finished.

// File: rtl/i2cmem_pkg.sv
package i2cmem_pkg;

  localparam logic [3:0] TYPE_CODE = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CTRL,
    ST_ADDR_HI,
    ST_ADDR_LO,
    ST_WDATA,
    ST_RDATA
  } engState_t;

  typedef enum logic [1:0] {
    DRV_HOLD,
    DRV_ACK,
    DRV_RELEASE
  } drvCmd_t;

  typedef struct packed {
    logic    loadAddrHi;
    logic    loadPtr;
    logic    storeByte;
    logic    loadTx;
    logic    shiftTx;
    logic    startCommit;
    logic    clearPage;
    drvCmd_t drv;
  } ctlStrobe_t;

endpackage

// File: rtl/i2cmem_ctrl.sv
module i2cmem_ctrl
  import i2cmem_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] selPins,
  input  logic       sclRise,
  input  logic       sclFall,
  input  logic       startSeen,
  input  logic       stopSeen,
  input  logic       sdaLvl,
  input  logic [7:0] rxByte,
  input  logic       busy,
  output ctlStrobe_t stb,
  output engState_t  engState
);

  engState_t stateN;
  logic [3:0] bitCnt, bitN;
  logic masterAck, ackN;
  logic isRead, rdN;
  logic wrPending, pendN;
  logic ctrlMatch;

  assign ctrlMatch = (rxByte[7:4] == TYPE_CODE) && (rxByte[3:1] == selPins) && !busy;

  always_comb begin
    stb     = '0;
    stb.drv = DRV_HOLD;
    stateN  = engState;
    bitN    = bitCnt;
    ackN    = masterAck;
    rdN     = isRead;
    pendN   = wrPending;
    if (stopSeen) begin
      stateN  = ST_IDLE;
      stb.drv = DRV_RELEASE;
      stb.startCommit = wrPending;
      pendN   = 1'b0;
    end else if (startSeen) begin
      stateN  = ST_CTRL;
      bitN    = 4'd0;
      stb.drv = DRV_RELEASE;
      stb.clearPage = 1'b1;
      pendN   = 1'b0;
    end else if (engState != ST_IDLE) begin
      if (sclRise) begin
        if (bitCnt < 4'd9) bitN = bitCnt + 4'd1;
        if (bitCnt == 4'd8 && engState == ST_RDATA) ackN = ~sdaLvl;
      end else if (sclFall) begin
        if (bitCnt == 4'd8) begin
          unique case (engState)
            ST_CTRL: begin
              if (ctrlMatch) begin
                stb.drv = DRV_ACK;
                rdN     = rxByte[0];
              end else begin
                stateN  = ST_IDLE;
              end
            end
            ST_ADDR_HI: begin
              stb.drv = DRV_ACK;
              stb.loadAddrHi = 1'b1;
            end
            ST_ADDR_LO: begin
              stb.drv = DRV_ACK;
              stb.loadPtr = 1'b1;
            end
            ST_WDATA: begin
              stb.drv = DRV_ACK;
              stb.storeByte = 1'b1;
              pendN = 1'b1;
            end
            ST_RDATA: stb.drv = DRV_RELEASE;
            default: ;
          endcase
        end else if (bitCnt == 4'd9) begin
          bitN = 4'd0;
          unique case (engState)
            ST_CTRL: begin
              if (isRead) begin
                stateN = ST_RDATA;
                stb.loadTx = 1'b1;
              end else begin
                stateN  = ST_ADDR_HI;
                stb.drv = DRV_RELEASE;
              end
            end
            ST_ADDR_HI: begin
              stateN  = ST_ADDR_LO;
              stb.drv = DRV_RELEASE;
            end
            ST_ADDR_LO: begin
              stateN  = ST_WDATA;
              stb.drv = DRV_RELEASE;
            end
            ST_WDATA: stb.drv = DRV_RELEASE;
            ST_RDATA: begin
              if (masterAck) begin
                stb.loadTx = 1'b1;
              end else begin
                stateN  = ST_IDLE;
                stb.drv = DRV_RELEASE;
              end
            end
            default: ;
          endcase
        end else if (engState == ST_RDATA && bitCnt != 4'd0) begin
          stb.shiftTx = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      engState  <= ST_IDLE;
      bitCnt    <= 4'd0;
      masterAck <= 1'b0;
      isRead    <= 1'b0;
      wrPending <= 1'b0;
    end else begin
      engState  <= stateN;
      bitCnt    <= bitN;
      masterAck <= ackN;
      isRead    <= rdN;
      wrPending <= pendN;
    end
  end

endmodule

// File: rtl/i2cmem_dpath.sv
module i2cmem_dpath
  import i2cmem_pkg::*;
#(
  parameter int ADDR_W       = 15,
  parameter int ARRAY_AW     = 10,
  parameter int PAGE_AW      = 6,
  parameter int WRITE_CYCLES = 1000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  ctlStrobe_t        stb,
  output logic              sclRise,
  output logic              sclFall,
  output logic              startSeen,
  output logic              stopSeen,
  output logic              sdaLvl,
  output logic [7:0]        rxByte,
  output logic              busy,
  output logic              sdaOe,
  output logic [ADDR_W-1:0] curPtr
);

  localparam int HI_W   = ADDR_W - 8;
  localparam int PAGE   = 1 << PAGE_AW;
  localparam int DEPTH  = 1 << ARRAY_AW;
  localparam int CNT_W  = $clog2(WRITE_CYCLES + 1);
  localparam int BASE_W = ADDR_W - PAGE_AW;

  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  logic sclLvl, sclPrev, sdaPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclLvl;
      sdaPrev <= sdaLvl;
    end
  end

  assign sclLvl    = sclPipe[SYNC_STAGES-1];
  assign sdaLvl    = sdaPipe[SYNC_STAGES-1];
  assign sclRise   = sclLvl & ~sclPrev;
  assign sclFall   = ~sclLvl & sclPrev;
  assign startSeen = sclLvl & sclPrev & sdaPrev & ~sdaLvl;
  assign stopSeen  = sclLvl & sclPrev & ~sdaPrev & sdaLvl;

  logic [7:0] rxShift, txShift, rdByte;
  logic [HI_W-1:0] addrHi;
  logic [7:0] pageBuf [PAGE];
  logic [PAGE-1:0] pageValid;
  logic [7:0] memArr [DEPTH];
  logic [CNT_W-1:0] busyCnt;
  logic [PAGE_AW:0] commitIdx;
  logic [BASE_W-1:0] pageBase;
  logic [ADDR_W-1:0] commitAddr;
  logic commitEn;

  assign rxByte     = rxShift;
  assign busy       = (busyCnt != '0);
  assign rdByte     = memArr[curPtr[ARRAY_AW-1:0]];
  assign commitAddr = {pageBase, commitIdx[PAGE_AW-1:0]};
  assign commitEn   = busy && !commitIdx[PAGE_AW] && pageValid[commitIdx[PAGE_AW-1:0]];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift   <= 8'd0;
      txShift   <= 8'd0;
      addrHi    <= '0;
      curPtr    <= '0;
      sdaOe     <= 1'b0;
      pageValid <= '0;
      busyCnt   <= '0;
      commitIdx <= '0;
      pageBase  <= '0;
    end else begin
      if (sclRise) rxShift <= {rxShift[6:0], sdaLvl};
      if (stb.loadAddrHi) addrHi <= rxShift[HI_W-1:0];

      if (stb.loadPtr)
        curPtr <= {addrHi, rxShift};
      else if (stb.storeByte)
        curPtr <= {curPtr[ADDR_W-1:PAGE_AW], curPtr[PAGE_AW-1:0] + PAGE_AW'(1)};
      else if (stb.loadTx)
        curPtr <= curPtr + ADDR_W'(1);

      if (stb.loadTx) begin
        txShift <= rdByte;
        sdaOe   <= ~rdByte[7];
      end else if (stb.shiftTx) begin
        txShift <= {txShift[6:0], 1'b0};
        sdaOe   <= ~txShift[6];
      end else if (stb.drv == DRV_ACK) begin
        sdaOe <= 1'b1;
      end else if (stb.drv == DRV_RELEASE) begin
        sdaOe <= 1'b0;
      end

      if (stb.clearPage && !busy) pageValid <= '0;
      else if (stb.storeByte) pageValid[curPtr[PAGE_AW-1:0]] <= 1'b1;
      else if (commitEn) pageValid[commitIdx[PAGE_AW-1:0]] <= 1'b0;

      if (stb.startCommit) begin
        busyCnt   <= CNT_W'(WRITE_CYCLES);
        commitIdx <= '0;
        pageBase  <= curPtr[ADDR_W-1:PAGE_AW];
      end else if (busy) begin
        busyCnt <= busyCnt - CNT_W'(1);
        if (!commitIdx[PAGE_AW]) commitIdx <= commitIdx + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (stb.storeByte) pageBuf[curPtr[PAGE_AW-1:0]] <= rxShift;
  end

  always_ff @(posedge clk) begin
    if (commitEn) memArr[commitAddr[ARRAY_AW-1:0]] <= pageBuf[commitIdx[PAGE_AW-1:0]];
  end

endmodule

// File: rtl/i2cmem_slave.sv
module i2cmem_slave
  import i2cmem_pkg::*;
#(
  parameter int ADDR_W       = 15,
  parameter int ARRAY_AW     = 10,
  parameter int PAGE_AW      = 6,
  parameter int WRITE_CYCLES = 1000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [2:0] selPins,
  output logic       sdaOe
);

  ctlStrobe_t stb;
  engState_t engState;
  logic sclRise, sclFall, startSeen, stopSeen, sdaLvl, busy;
  logic [7:0] rxByte;
  logic [ADDR_W-1:0] curPtr;

  i2cmem_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .selPins(selPins),
    .sclRise(sclRise), .sclFall(sclFall),
    .startSeen(startSeen), .stopSeen(stopSeen),
    .sdaLvl(sdaLvl), .rxByte(rxByte), .busy(busy),
    .stb(stb), .engState(engState)
  );

  i2cmem_dpath #(
    .ADDR_W(ADDR_W), .ARRAY_AW(ARRAY_AW), .PAGE_AW(PAGE_AW),
    .WRITE_CYCLES(WRITE_CYCLES), .SYNC_STAGES(SYNC_STAGES)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .stb(stb),
    .sclRise(sclRise), .sclFall(sclFall),
    .startSeen(startSeen), .stopSeen(stopSeen),
    .sdaLvl(sdaLvl), .rxByte(rxByte), .busy(busy),
    .sdaOe(sdaOe), .curPtr(curPtr)
  );

endmodule

// File: rtl/i2cmem_slave_chk.sv
module i2cmem_slave_chk #(
  parameter int ADDR_W  = 15,
  parameter int PAGE_AW = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              sdaOe,
  input logic              sclFall,
  input logic              startSeen,
  input logic              stopSeen,
  input logic              busy,
  input logic              loadTx,
  input logic              storeByte,
  input logic [4:0]        xferStb,
  input logic [ADDR_W-1:0] curPtr
);

  // R4, R10: the pull-down only moves right after a detected clock fall
  a_r4_oe_moves_after_fall: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> $past(sclFall));

  // R9: silent for the whole busy window
  a_r9_busy_silent: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !sdaOe);

  // R1: line released after a Start and after a Stop
  a_r1_start_release: assert property (@(posedge clk) disable iff (!rstN)
    startSeen |=> !sdaOe);
  a_r1_stop_release: assert property (@(posedge clk) disable iff (!rstN)
    stopSeen |=> !sdaOe);

  // R8: every read fetch advances the pointer by one, wrapping at the top
  a_r8_ptr_step: assert property (@(posedge clk) disable iff (!rstN)
    loadTx |=> curPtr == ADDR_W'($past(curPtr) + ADDR_W'(1)));

  // R5: a stored write byte keeps the page bits of the pointer
  a_r5_page_kept: assert property (@(posedge clk) disable iff (!rstN)
    storeByte |=> curPtr[ADDR_W-1:PAGE_AW] == $past(curPtr[ADDR_W-1:PAGE_AW]));

  // R10: at most one datapath transfer action per cycle
  a_r10_one_action: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(xferStb));

endmodule

bind i2cmem_slave i2cmem_slave_chk #(.ADDR_W(ADDR_W), .PAGE_AW(PAGE_AW)) u_chk (
  .clk(clk), .rstN(rstN), .sdaOe(sdaOe), .sclFall(sclFall),
  .startSeen(startSeen), .stopSeen(stopSeen), .busy(busy),
  .loadTx(stb.loadTx), .storeByte(stb.storeByte),
  .xferStb({stb.loadTx, stb.shiftTx, stb.storeByte, stb.loadPtr, stb.loadAddrHi}),
  .curPtr(curPtr)
);

// File: tb/tb_i2cmem_slave.sv
`timescale 1ns/1ps
module tb_i2cmem_slave;

  localparam int QTR  = 4;
  localparam int WCYC = 600;
  localparam int AAW  = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scl = 1'b1;
  logic sdaM = 1'b1;
  logic [2:0] sel = 3'b101;
  logic sdaOe;
  wire  sdaBus = sdaM & ~sdaOe;

  int nChecks = 0;
  int nFails  = 0;

  logic [7:0] refMem [1 << AAW];
  bit         known  [1 << AAW];
  logic [14:0] refPtr = 15'd0;

  always #2 clk = ~clk;

  i2cmem_slave #(.WRITE_CYCLES(WCYC)) dut (
    .clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sdaBus),
    .selPins(sel), .sdaOe(sdaOe)
  );

  function automatic logic [7:0] ctrlByte(input bit rd);
    return {4'b1010, sel, rd};
  endfunction

  function automatic logic [14:0] pageNext(input logic [14:0] p);
    return {p[14:6], 6'(p[5:0] + 6'd1)};
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic q();
    repeat (QTR) @(negedge clk);
  endtask

  task automatic i2cStart();
    sdaM = 1'b1; q();
    scl = 1'b1; q(); q();
    sdaM = 1'b0; q(); q();
    scl = 1'b0; q();
  endtask

  task automatic i2cStop();
    sdaM = 1'b0; q();
    scl = 1'b1; q();
    sdaM = 1'b1; q(); q();
  endtask

  task automatic writeBit(input bit b);
    sdaM = b; q();
    scl = 1'b1; q(); q();
    scl = 1'b0; q();
  endtask

  task automatic readBit(output bit b);
    sdaM = 1'b1; q();
    scl = 1'b1; q();
    b = sdaBus; q();
    scl = 1'b0; q();
  endtask

  task automatic sendByte(input logic [7:0] d, output bit acked);
    bit a;
    for (int i = 7; i >= 0; i--) writeBit(d[i]);
    readBit(a);
    acked = !a;
  endtask

  task automatic recvByte(input bit giveAck, output logic [7:0] d);
    bit b;
    for (int i = 7; i >= 0; i--) begin
      readBit(b);
      d[i] = b;
    end
    writeBit(!giveAck);
  endtask

  task automatic pollReady(input string tag);
    bit a;
    for (int i = 0; i < 40; i++) begin
      i2cStart();
      sendByte(ctrlByte(1'b0), a);
      i2cStop();
      if (i == 0) check(!a, tag, a, 0);
      if (a) break;
    end
    check(a, "R9 write cycle ends", a, 1);
  endtask

  task automatic writeTxn(input logic [14:0] addr, input int n, input string tag);
    bit a;
    logic [7:0] d;
    logic [14:0] p;
    i2cStart();
    sendByte(ctrlByte(1'b0), a);
    check(a, "R2 control write ack", a, 1);
    sendByte({1'($urandom), addr[14:8]}, a);
    sendByte(addr[7:0], a);
    check(a, "R3 address ack", a, 1);
    p = addr;
    for (int i = 0; i < n; i++) begin
      d = 8'($urandom);
      sendByte(d, a);
      if (i == 0) check(a, "R5 data ack", a, 1);
      refMem[p[AAW-1:0]] = d;
      known[p[AAW-1:0]] = 1'b1;
      p = pageNext(p);
    end
    i2cStop();
    refPtr = p;
    pollReady(tag);
  endtask

  task automatic readSeq(input bit setAddr, input logic [14:0] addr, input int len, input string tag);
    bit a;
    logic [7:0] d;
    if (setAddr) begin
      i2cStart();
      sendByte(ctrlByte(1'b0), a);
      sendByte({1'($urandom), addr[14:8]}, a);
      sendByte(addr[7:0], a);
      refPtr = addr;
    end
    i2cStart();
    sendByte(ctrlByte(1'b1), a);
    check(a, "R2 control read ack", a, 1);
    for (int i = 0; i < len; i++) begin
      recvByte(i < len - 1, d);
      if (known[refPtr[AAW-1:0]])
        check(d == refMem[refPtr[AAW-1:0]], tag, d, refMem[refPtr[AAW-1:0]]);
      refPtr = refPtr + 15'd1;
    end
    i2cStop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nFails++;
    $display("FAIL R9 watchdog expired: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    bit a;
    logic [7:0] d;
    void'($urandom(32'd2024));
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    // R1: released after reset
    check(sdaOe == 1'b0, "R1 reset released", sdaOe, 0);

    // R4: ack window on the control byte
    i2cStart();
    for (int i = 7; i >= 1; i--) writeBit(ctrlByte(1'b0)[i]);
    check(sdaOe == 1'b0, "R4 no drive before bit 8 fall", sdaOe, 0);
    writeBit(ctrlByte(1'b0)[0]);
    check(sdaOe == 1'b1, "R4 ack driven after bit 8 fall", sdaOe, 1);
    readBit(a);
    check(a == 1'b0, "R4 ack seen on bus", a, 0);
    check(sdaOe == 1'b0, "R4 ack released after bit 9 fall", sdaOe, 0);
    i2cStop();

    // R2: wrong type code and wrong select bits are ignored
    i2cStart();
    sendByte({4'b1011, sel, 1'b0}, a);
    check(!a, "R2 wrong type code nack", a, 0);
    check(sdaOe == 1'b0, "R2 line idle after mismatch", sdaOe, 0);
    i2cStop();
    i2cStart();
    sendByte({4'b1010, ~sel, 1'b1}, a);
    check(!a, "R2 wrong select nack", a, 0);
    i2cStop();

    // R3, R5, R9: small write, busy polling, readback
    writeTxn(15'h0123, 3, "R9 poll nack while busy");
    readSeq(1'b1, 15'h0123, 3, "R3 readback after address");

    // R6: current-address read continues from the stored pointer
    writeTxn(15'h0126, 2, "R9 poll nack while busy");
    readSeq(1'b1, 15'h0125, 1, "R7 random read byte");
    readSeq(1'b0, 15'h0, 2, "R6 current address read");

    // R7: random read starts no write cycle
    readSeq(1'b1, 15'h0124, 1, "R10 MSB first data");
    i2cStart();
    sendByte(ctrlByte(1'b0), a);
    check(a, "R7 no write cycle after random read", a, 1);
    i2cStop();

    // R8: rollover from 0x7FFF to 0x0000
    writeTxn(15'h7FFF, 1, "R9 poll nack while busy");
    writeTxn(15'h0000, 2, "R9 poll nack while busy");
    readSeq(1'b1, 15'h7FFF, 2, "R8 rollover sequential read");
    readSeq(1'b0, 15'h0, 1, "R8 pointer after rollover");

    // R5: page wrap with overwrite
    writeTxn(15'h023E, 66, "R9 poll nack while busy");
    readSeq(1'b1, 15'h0200, 64, "R5 page wrap contents");

    // R11: repeated Start discards page data
    writeTxn(15'h0300, 1, "R9 poll nack while busy");
    i2cStart();
    sendByte(ctrlByte(1'b0), a);
    sendByte(8'h03, a);
    sendByte(8'h00, a);
    sendByte(~refMem[10'h300], a);
    i2cStart();
    sendByte(ctrlByte(1'b0), a);
    check(a, "R11 no write cycle after repeated start", a, 1);
    i2cStop();
    readSeq(1'b1, 15'h0300, 1, "R11 old data kept");

    // R11: Start in the middle of a byte aborts it
    i2cStart();
    writeBit(1'b1); writeBit(1'b0); writeBit(1'b1);
    i2cStart();
    sendByte(ctrlByte(1'b1), a);
    check(a, "R11 control after aborted byte", a, 1);
    recvByte(1'b0, d);
    if (known[refPtr[AAW-1:0]])
      check(d == refMem[refPtr[AAW-1:0]], "R11 read after abort", d, refMem[refPtr[AAW-1:0]]);
    refPtr = refPtr + 15'd1;
    i2cStop();

    // Random mix
    for (int k = 0; k < 16; k++) begin
      int op;
      logic [14:0] ad;
      op = int'($urandom_range(2, 0));
      ad = 15'($urandom);
      case (op)
        0: writeTxn(ad, int'($urandom_range(10, 1)), "R9 poll nack while busy");
        1: readSeq(1'b1, ad, int'($urandom_range(4, 1)), "R8 random sequential read");
        default: readSeq(1'b0, 15'h0, int'($urandom_range(3, 1)), "R6 random current read");
      endcase
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule